// File: doc/BRIEF.md
# Flash Query-Mode Command Responder

This block sits between a host word bus and the array of a multi-bank NOR-style flash model. It decodes host word writes and, when it sees the query entry command, places the addressed bank into query mode. While a bank is in query mode, reads from that bank return words from a fixed identification and system-interface table instead of array contents. A reset command written to that bank restores normal array reads.

Only one bank can be in query mode at a time. Banks other than the query bank stay readable and return array data. All writes are held back from the array write port while query mode is active. The array itself is outside the block: array read data arrives on an input port for the bank and offset presented with the read strobe, and writes that are allowed through leave on a write port in the same cycle. Read data is registered and is valid one cycle after the read strobe.

Top module: `cfi_query_resp`

## Requirements
- R1: While `rst_ni` is low, the block leaves query mode, and `rdata_valid_o` and `rdata_o` are 0.
- R2: A write of data 0098h to word offset 555h of any bank while `ready_i` is high and no bank is in query mode puts that bank into query mode from the next cycle on.
- R3: The entry write of R2 made while `ready_i` is low is ignored: the bank keeps returning array data.
- R4: While in query mode, a write of data 00F0h at any offset of the query bank leaves query mode, and the next read of that bank returns array data.
- R5: In the query bank, offsets 10h, 11h and 12h read as 0051h, 0052h and 0059h.
- R6: In the query bank, offsets 13h to 1Ah read in order as 0002h, 0000h, 0040h, 0000h, 0000h, 0000h, 0000h, 0000h.
- R7: In the query bank, offsets 1Bh to 26h read in order as 0017h, 0019h, 0000h, 0000h, 0006h, 0009h, 000Ah, 0000h, 0004h, 0004h, 0003h, 0000h.
- R8: In the query bank, any offset below 10h or above 26h reads as 0000h.
- R9: While one bank is in query mode, reads from any other bank return the array data presented on `arr_rdata_i`.
- R10: Outside query mode, a write that is not the entry pattern (data 0098h at offset 555h) appears on the array write port in the same cycle with its bank, offset and data. In query mode, no write reaches that port, and the entry pattern never does.
- R11: `rdata_valid_o` is high exactly in the cycle after each cycle with `rd_en_i` high, with `rdata_o` holding the word selected in the strobe cycle; back-to-back strobes give back-to-back results.
- R12: While in query mode, writes other than 00F0h to the query bank, including a new entry command to another bank, change neither the mode nor the query bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ready_i | input | 1 | Device ready to read array data |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| bank_i | input | BANK_W | Bank select |
| addr_i | input | ADDR_W | Word offset within the bank |
| wdata_i | input | DATA_W | Host write data |
| arr_rdata_i | input | DATA_W | Array word for the current bank and offset |
| arr_we_o | output | 1 | Array write strobe |
| arr_bank_o | output | BANK_W | Array write bank |
| arr_addr_o | output | ADDR_W | Array write offset |
| arr_wdata_o | output | DATA_W | Array write data |
| rdata_o | output | DATA_W | Registered read data |
| rdata_valid_o | output | 1 | Read data valid |

## Verification
On every cycle, assertions check the mode transitions: entry is taken with the bank index captured, entry is refused while not ready, exit happens on the reset command, and the mode and bank hold otherwise. They also check one-cycle read validity, array pass-through for reads outside the query bank and zero data outside the table. The exact table contents at each offset, the return to array data after exit, and which writes reach the array port are shown only by the bench scenarios. Those scenarios walk the full table and probe its boundary offsets, the other banks and the ignored commands.

// File: rtl/cfi_query_pkg.sv
package cfi_query_pkg;
  localparam logic [15:0] ENTRY_CMD = 16'h0098;
  localparam logic [15:0] EXIT_CMD  = 16'h00F0;
  localparam int unsigned ENTRY_OFS = 'h555;
  localparam int unsigned TBL_LO    = 'h10;
  localparam int unsigned TBL_HI    = 'h26;

  // table word for offset 10h..26h; caller guarantees range
  function automatic logic [15:0] tbl_word(input logic [5:0] ofs);
    case (ofs)
      6'h10: tbl_word = 16'h0051;
      6'h11: tbl_word = 16'h0052;
      6'h12: tbl_word = 16'h0059;
      6'h13: tbl_word = 16'h0002;
      6'h15: tbl_word = 16'h0040;
      6'h1B: tbl_word = 16'h0017;
      6'h1C: tbl_word = 16'h0019;
      6'h1F: tbl_word = 16'h0006;
      6'h20: tbl_word = 16'h0009;
      6'h21: tbl_word = 16'h000A;
      6'h23: tbl_word = 16'h0004;
      6'h24: tbl_word = 16'h0004;
      6'h25: tbl_word = 16'h0003;
      default: tbl_word = 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/cfi_cmd_dec.sv
module cfi_cmd_dec #(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ready_i,
  input  logic              wr_en_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              entry_pat_o,
  output logic              qmode_o,
  output logic [BANK_W-1:0] qbank_o
);
  import cfi_query_pkg::*;

  logic              qmode_q;
  logic [BANK_W-1:0] qbank_q;
  logic              enter, leave;

  assign entry_pat_o = wr_en_i && (addr_i == ADDR_W'(ENTRY_OFS))
                       && (wdata_i == DATA_W'(ENTRY_CMD));
  assign enter = entry_pat_o && ready_i && !qmode_q;
  assign leave = qmode_q && wr_en_i && (bank_i == qbank_q)
                 && (wdata_i == DATA_W'(EXIT_CMD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qmode_q <= 1'b0;
      qbank_q <= '0;
    end else if (enter) begin
      qmode_q <= 1'b1;
      qbank_q <= bank_i;
    end else if (leave) begin
      qmode_q <= 1'b0;
    end
  end

  assign qmode_o = qmode_q;
  assign qbank_o = qbank_q;

  // R2
  enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ready_i && !qmode_q && addr_i == ADDR_W'(ENTRY_OFS)
     && wdata_i == DATA_W'(ENTRY_CMD)) |=> (qmode_q && qbank_q == $past(bank_i)));
  // R3
  not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!qmode_q && !ready_i) |=> !qmode_q);
  // R4
  exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qmode_q && wr_en_i && bank_i == qbank_q && wdata_i == DATA_W'(EXIT_CMD)) |=> !qmode_q);
  // R12
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qmode_q && !(wr_en_i && bank_i == qbank_q && wdata_i == DATA_W'(EXIT_CMD)))
    |=> (qmode_q && $stable(qbank_q)));
endmodule

// File: rtl/cfi_qtable.sv
module cfi_qtable #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] word_o
);
  import cfi_query_pkg::*;

  assign hit_o  = (addr_i >= ADDR_W'(TBL_LO)) && (addr_i <= ADDR_W'(TBL_HI));
  // out-of-range offsets give a fixed invalid word of zero
  assign word_o = hit_o ? DATA_W'(tbl_word(addr_i[5:0])) : '0;
endmodule

// File: rtl/cfi_rd_path.sv
module cfi_rd_path #(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              qmode_i,
  input  logic [BANK_W-1:0] qbank_i,
  input  logic              tbl_hit_i,
  input  logic [DATA_W-1:0] tbl_word_i,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o
);
  logic              use_tbl;
  logic [DATA_W-1:0] rdata_q;
  logic              valid_q;

  assign use_tbl = qmode_i && (bank_i == qbank_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= use_tbl ? tbl_word_i : arr_rdata_i;
    end
  end

  assign rdata_o       = rdata_q;
  assign rdata_valid_o = valid_q;

  // R11
  rd_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rdata_valid_o);
  // R11
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rdata_valid_o);
  // R9
  arr_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !(qmode_i && bank_i == qbank_i)) |=> (rdata_o == $past(arr_rdata_i)));
  // R8
  oor_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && qmode_i && bank_i == qbank_i && !tbl_hit_i) |=> (rdata_o == '0));
endmodule

// File: rtl/cfi_query_resp.sv
module cfi_query_resp #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 16,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ready_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic              arr_we_o,
  output logic [BANK_W-1:0] arr_bank_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o
);
  logic              entry_pat;
  logic              qmode;
  logic [BANK_W-1:0] qbank;
  logic              tbl_hit;
  logic [DATA_W-1:0] tbl_word;

  cfi_cmd_dec #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ready_i     (ready_i),
    .wr_en_i     (wr_en_i),
    .bank_i      (bank_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .entry_pat_o (entry_pat),
    .qmode_o     (qmode),
    .qbank_o     (qbank)
  );

  cfi_qtable #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tbl (
    .addr_i (addr_i),
    .hit_o  (tbl_hit),
    .word_o (tbl_word)
  );

  cfi_rd_path #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_en_i       (rd_en_i),
    .bank_i        (bank_i),
    .qmode_i       (qmode),
    .qbank_i       (qbank),
    .tbl_hit_i     (tbl_hit),
    .tbl_word_i    (tbl_word),
    .arr_rdata_i   (arr_rdata_i),
    .rdata_o       (rdata_o),
    .rdata_valid_o (rdata_valid_o)
  );

  // commands never reach the array; query mode blocks all writes
  assign arr_we_o    = wr_en_i && !qmode && !entry_pat;
  assign arr_bank_o  = bank_i;
  assign arr_addr_o  = addr_i;
  assign arr_wdata_o = wdata_i;

  // R1
  rst_quiet_chk: assert property (@(posedge clk_i) !rst_ni |-> (!rdata_valid_o && rdata_o == '0));
endmodule

// File: tb/cfi_query_resp_tb.sv
module cfi_query_resp_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 2;
  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ready, wr_en, rd_en;
  logic [BW-1:0] bank;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, arr_rdata;
  logic arr_we;
  logic [BW-1:0] arr_bank;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata, rdata;
  logic rvalid;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] arr_model(input logic [BW-1:0] b, input logic [AW-1:0] a);
    return {b, a, 2'b01} ^ 16'h3C00;
  endfunction

  function automatic logic [DW-1:0] tbl_model(input int a);
    logic [15:0] w [0:22];
    w = '{16'h0051, 16'h0052, 16'h0059, 16'h0002, 16'h0000, 16'h0040, 16'h0000,
          16'h0000, 16'h0000, 16'h0000, 16'h0000,
          16'h0017, 16'h0019, 16'h0000, 16'h0000, 16'h0006, 16'h0009, 16'h000A,
          16'h0000, 16'h0004, 16'h0004, 16'h0003, 16'h0000};
    if (a < 'h10 || a > 'h26) return 16'h0000;
    return w[a - 'h10];
  endfunction

  assign arr_rdata = arr_model(bank, addr);

  cfi_query_resp #(.NUM_BANKS(4), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ready_i(ready), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .bank_i(bank), .addr_i(addr), .wdata_i(wdata), .arr_rdata_i(arr_rdata),
    .arr_we_o(arr_we), .arr_bank_o(arr_bank), .arr_addr_o(arr_addr),
    .arr_wdata_o(arr_wdata), .rdata_o(rdata), .rdata_valid_o(rvalid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: one read per call, expected result queued
  task automatic rd(input logic [BW-1:0] b, input int a, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; bank = b; addr = AW'(a);
    exp_q.push_back(exp);
    tag_q.push_back(req);
  endtask

  task automatic idle();
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(input logic [BW-1:0] b, input int a, input logic [DW-1:0] d,
                    input logic exp_we, input string req);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b1; bank = b; addr = AW'(a); wdata = d;
    #1;
    chk(req, {31'd0, arr_we}, {31'd0, exp_we});
    if (exp_we) chk(req, {arr_bank, arr_addr, arr_wdata}, {b, AW'(a), d});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && rvalid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R11: unexpected valid, actual %h expected none", rdata);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {16'd0, rdata}, {16'd0, e});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    ready = 1'b1; wr_en = 1'b0; rd_en = 1'b0; bank = '0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid", {31'd0, rvalid}, 32'd0);
    chk("R1 data", {16'd0, rdata}, 32'd0);
    rst_ni = 1'b1;

    // array mode
    rd(0, 'h10, arr_model(0, 'h10), "R9 array before entry");
    rd(1, 'h123, arr_model(1, 'h123), "R11 back-to-back");
    idle();
    @(negedge clk);
    chk("R11 valid drops", {31'd0, rvalid}, 32'd0);
    wr(2, 'h40, 16'hBEEF, 1'b1, "R10 array write forwarded");

    // entry refused when not ready
    ready = 1'b0;
    wr(1, 'h555, 16'h0098, 1'b0, "R10 entry pattern blocked");
    ready = 1'b1;
    rd(1, 'h10, arr_model(1, 'h10), "R3 not ready ignored");
    idle();

    // enter on bank 1
    wr(1, 'h555, 16'h0098, 1'b0, "R2 entry write");
    for (int a = 'h10; a <= 'h26; a++) begin
      string t;
      t = (a <= 'h12) ? "R5 id string" : (a <= 'h1A) ? "R6 command set" : "R7 interface";
      rd(1, a, tbl_model(a), t);
    end
    rd(1, 'h0F, 16'h0000, "R8 below table");
    rd(1, 'h27, 16'h0000, "R8 above table");
    rd(1, 'h555, 16'h0000, "R8 far offset");
    rd(0, 'h11, arr_model(0, 'h11), "R9 other bank");
    rd(3, 'h26, arr_model(3, 'h26), "R9 other bank");
    idle();

    wr(0, 'h40, 16'h1234, 1'b0, "R10 other bank write dropped");
    wr(1, 'h40, 16'h1234, 1'b0, "R10 query bank write dropped");
    wr(2, 'h555, 16'h0098, 1'b0, "R12 second entry");
    wr(0, 'h0, 16'h00F0, 1'b0, "R12 exit to wrong bank");
    rd(2, 'h10, arr_model(2, 'h10), "R12 bank not moved");
    rd(1, 'h10, 16'h0051, "R12 still in query");
    rd(0, 'h12, arr_model(0, 'h12), "R12 exit wrong bank ignored");
    idle();

    // exit
    wr(1, 'h0, 16'h00F0, 1'b0, "R4 exit write");
    rd(1, 'h10, arr_model(1, 'h10), "R4 array after exit");
    idle();
    wr(1, 'h40, 16'h5555, 1'b1, "R10 write after exit");

    // re-enter another bank, reset clears mode
    wr(3, 'h555, 16'h0098, 1'b0, "R2 entry bank 3");
    rd(3, 'h12, 16'h0059, "R2 bank 3 query");
    idle();
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R1 valid in reset", {31'd0, rvalid}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    rd(3, 'h12, arr_model(3, 'h12), "R1 mode cleared");
    idle();
    repeat (3) @(negedge clk);
    chk("R11 queue drained", exp_q.size(), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule